// File: doc/BRIEF.md
# Vsync-Driven Layer Descriptor Loader

This block keeps the working registers of one display layer up to date by walking a linked list of descriptors held in memory. Each descriptor is sixteen 32-bit words. It describes one field or frame of the layer: control word, alpha gain, display window corners, pixel buffer address and pitch, source size, two colour-key words, a word that can hide the layer from the mixer, a colour lookup address, and a link to the descriptor that follows.

On each vertical sync the block reads the descriptor at its current node pointer through a simple one-word-at-a-time memory read port. It copies the fields into the shadow registers that drive the display pipeline, and then takes that descriptor's link word as the new node pointer. Two descriptors that link to each other make the layer alternate between them forever, for example for top and bottom fields. Software can point the chain at a new descriptor through a small register port. The new pointer is used at the next vsync, so relinking never tears a frame. The same port reads a status word with sticky error flags.

Top module: `layer_desc_loader`

## Requirements
- R1: After reset all layer outputs are zero, the layer is not shown, the pointer register (select 0) reads 0 and the status register (select 1) reads 0.
- R2: On a vsync with a non-zero, 16-byte-aligned pointer, the block issues exactly 16 read requests, one at a time. The byte addresses are base, base+4, ..., base+60, and a new request goes out only after the response to the previous one.
- R3: Descriptor word indices map as follows: 0 control, 1 alpha gain, 3 window origin, 4 window stop, 5 pixel address, 6 pitch, 7 size, 9 next node, 10 key low, 11 key high, 13 hide word, 15 lookup address. The width is size bits 15:0 and the height is size bits 31:16, each saturated to 2^DIM_W-1 (0x7FF by default).
- R4: If control bit 31 of a fetched descriptor is 0, its values reach the outputs when the fetch ends. If it is 1, they are held and reach the outputs at the following vsync. Between these events the outputs do not change.
- R5: When a fetch ends, the pointer takes the descriptor's next-node word. Two descriptors that link to each other are shown alternately on successive vsyncs.
- R6: A vsync with a pointer of zero issues no read and leaves the outputs unchanged.
- R7: A vsync with a pointer whose low 4 bits are not zero issues no read and sets status bit 1. Status bit 1 is sticky and is cleared by writing 1 to it.
- R8: A write to select 0 reads back at once but is used only at the next vsync, where it replaces the chained pointer.
- R9: lay_show is 0 whenever either of bits 1:0 of the active hide word is set.
- R10: A vsync that arrives while a fetch is still active sets status bit 0 and leaves the outputs unchanged. The running fetch completes and is applied, and then a fetch of the chained pointer starts. Bit 0 stays set until 1 is written to it.
- R11: At each vsync, lay_field_top and status bit 3 take the value of vsync_top. Status bit 2 is fetch-active and bit 4 is descriptor-loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | One-cycle vertical sync pulse |
| vsync_top | input | 1 | Field of this vsync, 1 = top |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = node pointer, 1 = status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| mem_rd_req | output | 1 | Read request, one cycle per word |
| mem_rd_addr | output | ADDR_W | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read response valid |
| mem_rd_data | input | 32 | Read response word |
| lay_ctrl | output | 32 | Active control word |
| lay_alpha | output | 32 | Active alpha gain |
| lay_origin | output | 32 | Window origin, x low half, y high half |
| lay_stop | output | 32 | Inclusive window stop, x low, y high |
| lay_pix_addr | output | 32 | Pixel buffer address |
| lay_pitch | output | 32 | Line pitch |
| lay_width | output | DIM_W | Saturated source width |
| lay_height | output | DIM_W | Saturated source height |
| lay_key_lo | output | 32 | Colour key low word |
| lay_key_hi | output | 32 | Colour key high word |
| lay_clut | output | 32 | Colour lookup address |
| lay_show | output | 1 | Layer loaded and not hidden |
| lay_field_top | output | 1 | Field of the last vsync |

## Verification
The bench builds the block with ADDR_W = 16 and DIM_W = 11, against a memory model with a two-cycle read latency. The 16-bit pointer fits the bench memory. DIM_W = 11 puts both sides of the saturation point (0x7FF exactly, and a height of 0x900) into the test descriptors. The two-cycle latency makes one fetch last about 48 cycles, so a second vsync a few cycles after the first lands in the middle of a fetch and drives the deferred-fetch path. The chain covers a self-alternating pair, a descriptor with the hold bit, a hidden descriptor whose link ends the chain, and a misaligned software pointer.

// File: rtl/ldl_pkg.sv
// Shared types and descriptor layout for the layer descriptor loader.
// Assumes a descriptor of 16 words of 32 bits; word indices below are the
// positions the fetch sequencer decodes.
package ldl_pkg;

    localparam int DESC_WORDS = 16;
    localparam int WORD_W     = 32;

    typedef logic [3:0] widx_t;

    localparam widx_t WI_CTL  = 4'd0;
    localparam widx_t WI_AGC  = 4'd1;
    localparam widx_t WI_ORG  = 4'd3;
    localparam widx_t WI_STP  = 4'd4;
    localparam widx_t WI_PIX  = 4'd5;
    localparam widx_t WI_PIT  = 4'd6;
    localparam widx_t WI_SIZE = 4'd7;
    localparam widx_t WI_NEXT = 4'd9;
    localparam widx_t WI_KLO  = 4'd10;
    localparam widx_t WI_KHI  = 4'd11;
    localparam widx_t WI_HIDE = 4'd13;
    localparam widx_t WI_LUT  = 4'd15;

    localparam int HOLD_BIT = 31;

    // Fields a descriptor contributes to the display pipeline.
    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] agc;
        logic [31:0] org;
        logic [31:0] stp;
        logic [31:0] pix;
        logic [31:0] pit;
        logic [31:0] size;
        logic [31:0] klo;
        logic [31:0] khi;
        logic [31:0] lut;
        logic [1:0]  hide;
    } disp_t;

endpackage

// File: rtl/ldl_fetch.sv
// Descriptor fetch sequencer.
// Reads the 16 words of one descriptor, one request at a time, from a
// word-read port and captures the fields. Assumes the memory answers every
// request exactly once, in order. `active` covers the busy period and the
// cycle in which `done` pulses.
module ldl_fetch #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              active,
    output logic              done,
    output ldl_pkg::disp_t    disp,
    output logic [31:0]       next_node
);
    import ldl_pkg::*;

    localparam widx_t LAST_IDX = widx_t'(DESC_WORDS - 1);

    logic              busy_q;
    logic              wait_q;
    logic              done_q;
    widx_t             idx_q;
    logic [ADDR_W-1:0] base_q;

    assign mem_rd_req  = busy_q && !wait_q;
    assign mem_rd_addr = base_q + ADDR_W'({idx_q, 2'b00});
    assign active      = busy_q || done_q;
    assign done        = done_q;

    // Sequencer: step through the words, one outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wait_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                wait_q <= 1'b0;
                idx_q  <= '0;
                base_q <= base;
            end else if (busy_q) begin
                if (mem_rd_req) begin
                    wait_q <= 1'b1;
                end else if (mem_rd_valid) begin
                    wait_q <= 1'b0;
                    if (idx_q == LAST_IDX) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    // Capture: steer each returned word into its field by word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp      <= '0;
            next_node <= '0;
        end else if (busy_q && wait_q && mem_rd_valid) begin
            case (idx_q)
                WI_CTL:  disp.ctl  <= mem_rd_data;
                WI_AGC:  disp.agc  <= mem_rd_data;
                WI_ORG:  disp.org  <= mem_rd_data;
                WI_STP:  disp.stp  <= mem_rd_data;
                WI_PIX:  disp.pix  <= mem_rd_data;
                WI_PIT:  disp.pit  <= mem_rd_data;
                WI_SIZE: disp.size <= mem_rd_data;
                WI_NEXT: next_node <= mem_rd_data;
                WI_KLO:  disp.klo  <= mem_rd_data;
                WI_KHI:  disp.khi  <= mem_rd_data;
                WI_HIDE: disp.hide <= mem_rd_data[1:0];
                WI_LUT:  disp.lut  <= mem_rd_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ldl_shadow.sv
// Shadow register bank for the layer.
// Applies a freshly fetched descriptor at once, or holds it until the next
// vsync when its control hold bit is set. A new fetch result in the same
// cycle as a vsync wins over the held one.
module ldl_shadow #(
    parameter int DIM_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync,
    input  logic               new_valid,
    input  ldl_pkg::disp_t     new_disp,
    output ldl_pkg::disp_t     act,
    output logic [DIM_W-1:0]   width,
    output logic [DIM_W-1:0]   height,
    output logic               loaded,
    output logic               show
);
    import ldl_pkg::*;

    localparam logic [15:0] DIM_MAX = 16'((1 << DIM_W) - 1);

    disp_t held_q;
    logic  held_v_q;

    // Commit path: held descriptor at vsync, immediate one at fetch end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= '0;
            held_q   <= '0;
            held_v_q <= 1'b0;
            loaded   <= 1'b0;
        end else begin
            if (vsync && held_v_q) begin
                act      <= held_q;
                held_v_q <= 1'b0;
                loaded   <= 1'b1;
            end
            if (new_valid) begin
                if (new_disp.ctl[HOLD_BIT]) begin
                    held_q   <= new_disp;
                    held_v_q <= 1'b1;
                end else begin
                    act    <= new_disp;
                    loaded <= 1'b1;
                end
            end
        end
    end

    // Saturate the size halves to the largest supported dimension.
    always_comb begin
        width  = (act.size[15:0]  > DIM_MAX) ? DIM_MAX[DIM_W-1:0] : act.size[DIM_W-1:0];
        height = (act.size[31:16] > DIM_MAX) ? DIM_MAX[DIM_W-1:0] : act.size[16 +: DIM_W];
        show   = loaded && (act.hide == 2'b00);
    end

endmodule

// File: rtl/layer_desc_loader.sv
// Layer descriptor loader, top level.
// On every vsync fetches the descriptor at the node pointer, then follows
// its link. Software sets the pointer through select 0 (used at the next
// vsync) and reads or clears sticky flags through select 1. Assumes vsync
// is a single-cycle pulse and ADDR_W is at least 4 and at most 32.
module layer_desc_loader #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              vsync_top,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic [31:0]       lay_ctrl,
    output logic [31:0]       lay_alpha,
    output logic [31:0]       lay_origin,
    output logic [31:0]       lay_stop,
    output logic [31:0]       lay_pix_addr,
    output logic [31:0]       lay_pitch,
    output logic [DIM_W-1:0]  lay_width,
    output logic [DIM_W-1:0]  lay_height,
    output logic [31:0]       lay_key_lo,
    output logic [31:0]       lay_key_hi,
    output logic [31:0]       lay_clut,
    output logic              lay_show,
    output logic              lay_field_top
);
    import ldl_pkg::*;

    localparam int ALIGN_BITS = 4;

    logic [ADDR_W-1:0] chain_q;
    logic [ADDR_W-1:0] sw_ptr_q;
    logic              sw_pend_q;
    logic              defer_q;
    logic              under_q;
    logic              err_q;
    logic              field_q;

    logic              f_active;
    logic              f_done;
    logic              f_start;
    disp_t             f_disp;
    logic [31:0]       f_next;
    disp_t             act;
    logic              loaded;

    logic              launch;
    logic [ADDR_W-1:0] fetch_addr;
    logic              addr_zero;
    logic              addr_mis;
    logic              wr_ptr;
    logic              wr_stat;

    assign launch     = (vsync || defer_q) && !f_active;
    assign fetch_addr = sw_pend_q ? sw_ptr_q : chain_q;
    assign addr_zero  = (fetch_addr == '0);
    assign addr_mis   = (fetch_addr[ALIGN_BITS-1:0] != '0);
    assign f_start    = launch && !addr_zero && !addr_mis;
    assign wr_ptr     = reg_wr && !reg_sel;
    assign wr_stat    = reg_wr && reg_sel;

    ldl_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (f_start),
        .base         (fetch_addr),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .active       (f_active),
        .done         (f_done),
        .disp         (f_disp),
        .next_node    (f_next)
    );

    ldl_shadow #(.DIM_W(DIM_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .new_valid (f_done),
        .new_disp  (f_disp),
        .act       (act),
        .width     (lay_width),
        .height    (lay_height),
        .loaded    (loaded),
        .show      (lay_show)
    );

    // Pointer chain: launch bookkeeping, link following, software relink.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q   <= '0;
            sw_ptr_q  <= '0;
            sw_pend_q <= 1'b0;
            defer_q   <= 1'b0;
        end else begin
            if (vsync && f_active) begin
                defer_q <= 1'b1;
            end
            if (launch) begin
                defer_q   <= 1'b0;
                sw_pend_q <= 1'b0;
                if (f_start) begin
                    chain_q <= fetch_addr;
                end
            end
            if (f_done) begin
                chain_q <= f_next[ADDR_W-1:0];
            end
            if (wr_ptr) begin
                sw_ptr_q  <= reg_wdata[ADDR_W-1:0];
                sw_pend_q <= 1'b1;
            end
        end
    end

    // Status flags: sticky errors with write-one-to-clear, field latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            under_q <= 1'b0;
            err_q   <= 1'b0;
            field_q <= 1'b0;
        end else begin
            if (wr_stat && reg_wdata[0]) under_q <= 1'b0;
            if (wr_stat && reg_wdata[1]) err_q   <= 1'b0;
            if (vsync && f_active)       under_q <= 1'b1;
            if (launch && !addr_zero && addr_mis) err_q <= 1'b1;
            if (vsync)                   field_q <= vsync_top;
        end
    end

    // Register read mux and layer output wiring.
    always_comb begin
        if (reg_sel) begin
            reg_rdata = {27'd0, loaded, field_q, f_active, err_q, under_q};
        end else begin
            reg_rdata = 32'(fetch_addr);
        end
        lay_ctrl      = act.ctl;
        lay_alpha     = act.agc;
        lay_origin    = act.org;
        lay_stop      = act.stp;
        lay_pix_addr  = act.pix;
        lay_pitch     = act.pit;
        lay_key_lo    = act.klo;
        lay_key_hi    = act.khi;
        lay_clut      = act.lut;
        lay_field_top = field_q;
    end

endmodule

// File: rtl/layer_desc_loader_chk.sv
// Property checker for the layer descriptor loader, bound to the top.
// Observes the memory port, the field output and internal flags.
module layer_desc_loader_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync,
    input logic              vsync_top,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              f_done,
    input logic              f_active,
    input logic              under_q,
    input logic [31:0]       lay_pix_addr,
    input logic              lay_field_top
);

    assert_single_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync && !f_done) |=> $stable(lay_pix_addr));

    assert_late_vsync_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && f_active) |=> under_q);

    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (under_q && !(reg_wr && reg_sel && reg_wdata[0])) |=> under_q);

    assert_field_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (lay_field_top == $past(vsync_top)));

endmodule

bind layer_desc_loader layer_desc_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vsync         (vsync),
    .vsync_top     (vsync_top),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .f_done        (f_done),
    .f_active      (f_active),
    .under_q       (under_q),
    .lay_pix_addr  (lay_pix_addr),
    .lay_field_top (lay_field_top)
);

// File: tb/layer_desc_loader_tb.sv
module layer_desc_loader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int DW         = 11;
    localparam int FETCH_WAIT = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync = 1'b0;
    logic          vsync_top = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid;
    logic [31:0]   mem_rd_data;
    logic [31:0]   lay_ctrl, lay_alpha, lay_origin, lay_stop, lay_pix_addr;
    logic [31:0]   lay_pitch, lay_key_lo, lay_key_hi, lay_clut;
    logic [DW-1:0] lay_width, lay_height;
    logic          lay_show, lay_field_top;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [0:127];
    logic [1:0]  vpipe;
    logic [AW-1:0] apipe0, apipe1;
    int req_cnt = 0;
    int req_idx = 0;
    int addr_err = 0;
    logic [AW-1:0] first_addr = '0;

    localparam logic [31:0] TAG_A = 32'h1000_0000;
    localparam logic [31:0] TAG_B = 32'h2000_0000;
    localparam logic [31:0] TAG_D = 32'h4000_0000;
    localparam logic [31:0] TAG_E = 32'h5000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    layer_desc_loader #(.ADDR_W(AW), .DIM_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .vsync_top(vsync_top),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .lay_ctrl(lay_ctrl), .lay_alpha(lay_alpha), .lay_origin(lay_origin),
        .lay_stop(lay_stop), .lay_pix_addr(lay_pix_addr), .lay_pitch(lay_pitch),
        .lay_width(lay_width), .lay_height(lay_height), .lay_key_lo(lay_key_lo),
        .lay_key_hi(lay_key_hi), .lay_clut(lay_clut), .lay_show(lay_show),
        .lay_field_top(lay_field_top)
    );

    // Memory model with a two-cycle read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= 2'b00;
        end else begin
            vpipe <= {vpipe[0], mem_rd_req};
        end
        apipe0 <= mem_rd_addr;
        apipe1 <= apipe0;
    end
    assign mem_rd_valid = vpipe[1];
    assign mem_rd_data  = mem[apipe1[8:2]];

    // Request monitor: counts requests and checks address stepping within a fetch.
    always @(posedge clk) begin
        if (rst_n && mem_rd_req) begin
            if (req_idx == 0) first_addr = mem_rd_addr;
            else if (mem_rd_addr != first_addr + AW'(4 * req_idx)) addr_err = addr_err + 1;
            req_idx = (req_idx + 1) % 16;
            req_cnt = req_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_vsync(input logic top);
        @(negedge clk);
        vsync = 1'b1;
        vsync_top = top;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_desc(input int w, input logic [31:0] ctl, input logic [31:0] tag,
                            input logic [31:0] sz, input logic [31:0] nxt, input logic [31:0] hide);
        for (int i = 0; i < 16; i++) mem[w + i] = 32'hBAD0_0000 + 32'(i);
        mem[w + 0]  = ctl;
        mem[w + 1]  = tag + 1;
        mem[w + 3]  = tag + 3;
        mem[w + 4]  = tag + 4;
        mem[w + 5]  = tag + 5;
        mem[w + 6]  = tag + 6;
        mem[w + 7]  = sz;
        mem[w + 9]  = nxt;
        mem[w + 10] = tag + 10;
        mem[w + 11] = tag + 11;
        mem[w + 13] = hide;
        mem[w + 15] = tag + 15;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 pix", lay_pix_addr, 32'h0);
        chk("R1 ctrl", lay_ctrl, 32'h0);
        chk("R1 show", 32'(lay_show), 32'h0);
        rd_reg(1'b0, d); chk("R1 pointer", d, 32'h0);
        rd_reg(1'b1, d); chk("R1 status", d, 32'h0);
    endtask

    task automatic t_zero_ptr;
        int c0 = req_cnt;
        logic [31:0] p0 = lay_pix_addr;
        pulse_vsync(1'b1);
        cycles(FETCH_WAIT);
        chk("R6 no reads", 32'(req_cnt - c0), 32'h0);
        chk("R6 pix unchanged", lay_pix_addr, p0);
    endtask

    task automatic t_first_fetch;
        logic [31:0] d;
        int c0;
        wr_reg(1'b0, 32'h40);
        rd_reg(1'b0, d); chk("R8 readback", d, 32'h40);
        c0 = req_cnt;
        cycles(10);
        chk("R8 no fetch before vsync", 32'(req_cnt - c0), 32'h0);
        pulse_vsync(1'b1);
        cycles(FETCH_WAIT);
        chk("R2 request count", 32'(req_cnt - c0), 32'd16);
        chk("R2 first address", 32'(first_addr), 32'h40);
        chk("R2 address steps", 32'(addr_err), 32'h0);
        chk("R3 ctrl", lay_ctrl, 32'h25);
        chk("R3 alpha", lay_alpha, TAG_A + 1);
        chk("R3 origin", lay_origin, TAG_A + 3);
        chk("R3 stop", lay_stop, TAG_A + 4);
        chk("R3 pix", lay_pix_addr, TAG_A + 5);
        chk("R3 pitch", lay_pitch, TAG_A + 6);
        chk("R3 key lo", lay_key_lo, TAG_A + 10);
        chk("R3 key hi", lay_key_hi, TAG_A + 11);
        chk("R3 clut", lay_clut, TAG_A + 15);
        chk("R3 width", 32'(lay_width), 32'h123);
        chk("R3 height saturated", 32'(lay_height), 32'h7FF);
        chk("R9 shown", 32'(lay_show), 32'h1);
        rd_reg(1'b0, d); chk("R5 pointer follows link", d, 32'h80);
        rd_reg(1'b1, d); chk("R11 status", d, 32'h18);
    endtask

    task automatic t_alternate;
        pulse_vsync(1'b0);
        cycles(FETCH_WAIT);
        chk("R5 second is B", lay_pix_addr, TAG_B + 5);
        chk("R3 width at limit", 32'(lay_width), 32'h7FF);
        chk("R3 height", 32'(lay_height), 32'h200);
        chk("R11 bottom field", 32'(lay_field_top), 32'h0);
        pulse_vsync(1'b1);
        cycles(FETCH_WAIT);
        chk("R5 back to A", lay_pix_addr, TAG_A + 5);
        chk("R11 top field", 32'(lay_field_top), 32'h1);
    endtask

    task automatic t_hold_bit;
        logic [31:0] d;
        wr_reg(1'b0, 32'hC0);
        pulse_vsync(1'b1);
        cycles(FETCH_WAIT);
        chk("R4 held not applied", lay_pix_addr, TAG_A + 5);
        rd_reg(1'b0, d); chk("R5 pointer to E", d, 32'h100);
        pulse_vsync(1'b0);
        cycles(2);
        chk("R4 applied at vsync", lay_pix_addr, TAG_D + 5);
        chk("R4 ctrl with hold bit", lay_ctrl, 32'h8000_0005);
        cycles(FETCH_WAIT);
        chk("R9 E loaded", lay_pix_addr, TAG_E + 5);
        chk("R9 hidden", 32'(lay_show), 32'h0);
        rd_reg(1'b0, d); chk("R5 end of chain", d, 32'h0);
    endtask

    task automatic t_misaligned;
        logic [31:0] d;
        int c0 = req_cnt;
        wr_reg(1'b0, 32'h48);
        pulse_vsync(1'b1);
        cycles(3);
        rd_reg(1'b1, d); chk("R7 error flag", d & 32'h2, 32'h2);
        chk("R7 no reads", 32'(req_cnt - c0), 32'h0);
        chk("R7 pix unchanged", lay_pix_addr, TAG_E + 5);
        wr_reg(1'b1, 32'h2);
        rd_reg(1'b1, d); chk("R7 flag cleared", d & 32'h2, 32'h0);
    endtask

    task automatic t_underflow;
        logic [31:0] d;
        int c0;
        wr_reg(1'b0, 32'h40);
        c0 = req_cnt;
        pulse_vsync(1'b1);
        cycles(5);
        pulse_vsync(1'b0);
        cycles(2);
        rd_reg(1'b1, d); chk("R10 underflow set", d & 32'h1, 32'h1);
        chk("R10 old values kept", lay_pix_addr, TAG_E + 5);
        cycles(130);
        chk("R10 deferred fetch applied", lay_pix_addr, TAG_B + 5);
        chk("R10 two fetches", 32'(req_cnt - c0), 32'd32);
        rd_reg(1'b0, d); chk("R10 pointer", d, 32'h40);
        rd_reg(1'b1, d); chk("R10 sticky", d & 32'h1, 32'h1);
        wr_reg(1'b1, 32'h1);
        rd_reg(1'b1, d); chk("R10 cleared", d & 32'h1, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        set_desc(16, 32'h25,         TAG_A, 32'h0900_0123, 32'h80,  32'h0);
        set_desc(32, 32'h25,         TAG_B, 32'h0200_07FF, 32'h40,  32'h0);
        set_desc(48, 32'h8000_0005,  TAG_D, 32'h0010_0010, 32'h100, 32'h0);
        set_desc(64, 32'h05,         TAG_E, 32'h0010_0010, 32'h0,   32'h2);
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_zero_ptr();
        t_first_fetch();
        t_alternate();
        t_hold_bit();
        t_zero_ptr();
        t_misaligned();
        t_underflow();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule